// File: doc/BRIEF.md
# Dual-Port RAM with Multiplexed Address/Data Port

This block is a 16-bit-wide memory with two ports that work on their own clock-cycle schedules. Both ports can read or write any word at any time. The left port carries address and data on one shared bus. A strobe cycle captures the address on that bus, and the read and write cycles that follow use the captured address. A strap input sets how the right port is addressed. With the strap low, the right port is a conventional SRAM port that takes its address from dedicated pins. With the strap high, the right port uses the same strobe-and-capture scheme as the left port.

Each port has these controls, all active low: select, write, output enable, upper-byte enable and lower-byte enable. It also has an active-high address strobe. The shared bus is modelled as three separate signals: data in, data out, and a two-bit per-byte drive enable. There is no tri-state logic. Data on a read is registered, so it appears on the outputs one cycle after the read cycle. The word width is fixed at 16 bits. The address width is a parameter that takes the value 12, 13 or 14.

Top module: `dpram_admux`

## Requirements
- R1: When a port is in multiplexed mode, a cycle with its address strobe high loads bus_in[ADDR_W-1:0] into that port's address register. This happens whatever the other controls are. That cycle performs neither a read nor a write, and the next cycle the bus drive is 2'b00. Every later access on that port uses the stored address until the next strobe.
- R2: With r_mux_mode=0, the right port takes its address from r_addr and ignores r_addr_stb completely. The strobe neither loads the right address register nor blocks an access in the same cycle. With r_mux_mode=1, the right port uses its stored address.
- R3: A read cycle has select low, write high, output enable low and strobe inactive. One cycle after a read cycle, bus_drv[0] is the inverse of the lower-byte enable and covers bits 7..0. bus_drv[1] is the inverse of the upper-byte enable and covers bits 15..8. The bytes that are driven carry the stored word, and any byte that is not driven reads as zero.
- R4: If select was high in a cycle, bus_drv is 2'b00 in the next cycle and no word is written.
- R5: If write and output enable were both high in a cycle, bus_drv is 2'b00 in the next cycle.
- R6: If both byte enables were high in a cycle, bus_drv is 2'b00 in the next cycle, and a write cycle changes no byte.
- R7: A write cycle has select low, write low and strobe inactive. It stores bus_in only into the bytes whose enables are low, and the other byte keeps its value. Output enable has no effect on a write, and bus_drv is 2'b00 in the next cycle.
- R8: Both ports can read the same word in the same cycle, and each returns the full stored value.
- R9: If both ports write the same word in the same cycle, the left port's byte wins in every byte lane that both ports enable. In a lane that only one port enables, that port's byte is stored.
- R10: If one port reads a word in the same cycle that the other port writes it, the read returns the value stored before that write.
- R11: While rst is high, both stored addresses return to 0 and both ports drive 2'b00 with zero data. A port that has had no strobe since reset accesses word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| r_mux_mode | input | 1 | Right-port strap: 0 selects the pin address, 1 selects the multiplexed bus |
| l_sel_n | input | 1 | Left port select, active low |
| l_wr_n | input | 1 | Left port write, active low |
| l_out_en_n | input | 1 | Left port output enable, active low |
| l_hi_en_n | input | 1 | Left port upper-byte enable, active low |
| l_lo_en_n | input | 1 | Left port lower-byte enable, active low |
| l_addr_stb | input | 1 | Left port address strobe |
| l_bus_in | input | 16 | Left port bus, inbound (address or write data) |
| l_bus_out | output | 16 | Left port bus, outbound read data |
| l_bus_drv | output | 2 | Left port per-byte drive enable (bit 1 = upper) |
| r_sel_n | input | 1 | Right port select, active low |
| r_wr_n | input | 1 | Right port write, active low |
| r_out_en_n | input | 1 | Right port output enable, active low |
| r_hi_en_n | input | 1 | Right port upper-byte enable, active low |
| r_lo_en_n | input | 1 | Right port lower-byte enable, active low |
| r_addr_stb | input | 1 | Right port address strobe (used only when r_mux_mode=1) |
| r_addr | input | ADDR_W | Right port dedicated address (used only when r_mux_mode=0) |
| r_bus_in | input | 16 | Right port bus or data pins, inbound |
| r_bus_out | output | 16 | Right port outbound read data |
| r_bus_drv | output | 2 | Right port per-byte drive enable (bit 1 = upper) |

## Verification
The properties assume that every control input settles between clock edges and is sampled once, at the rising edge. They also assume that a strobe cycle is a single cycle of its own, one that does not double as an access. The bench drives all inputs on the falling edge, so no input ever changes near the sampling edge. It also returns each port to its idle state after every strobe, read and write cycle. The bench changes r_mux_mode only while the right port is idle, because the properties decode the strap in the same cycle as the controls.

// File: rtl/dpram_admux_pkg.sv
package dpram_admux_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;

    typedef logic [LANES-1:0]  lane_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LATCH = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } port_op_e;

    typedef struct packed {
        lane_t lanes;
        word_t wdata;
    } wr_req_t;

    function automatic lane_t lanes_of(input logic hi_n, input logic lo_n);
        return {~hi_n, ~lo_n};
    endfunction

    function automatic port_op_e decode_op(
        input logic stb_used,
        input logic sel_n,
        input logic wr_n,
        input logic out_en_n,
        input lane_t lanes
    );
        port_op_e op;
        if (stb_used)
            op = OP_LATCH;
        else if (sel_n)
            op = OP_IDLE;
        else if (!wr_n)
            op = OP_WRITE;
        else if (!out_en_n && (lanes != '0))
            op = OP_READ;
        else
            op = OP_IDLE;
        return op;
    endfunction

    function automatic word_t mask_word(input word_t w, input lane_t lanes);
        word_t m;
        for (int i = 0; i < LANES; i++)
            m[i*BYTE_W +: BYTE_W] = lanes[i] ? w[i*BYTE_W +: BYTE_W] : '0;
        return m;
    endfunction

endpackage

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_admux_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mux_en,
    input  logic              stb,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic              hi_n,
    input  logic              lo_n,
    input  word_t             bus_in,
    input  logic [ADDR_W-1:0] pin_addr,
    input  word_t             rd_word,
    output logic [ADDR_W-1:0] acc_addr,
    output wr_req_t           wr_req,
    output word_t             bus_out,
    output lane_t             bus_drv
);

    lane_t             lanes;
    port_op_e          op;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        lanes = lanes_of(hi_n, lo_n);
        op    = decode_op(mux_en & stb, sel_n, wr_n, out_en_n, lanes);
    end

    // Captured bus address for multiplexed operation
    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (op == OP_LATCH)
            addr_q <= bus_in[ADDR_W-1:0];
    end

    assign acc_addr = mux_en ? addr_q : pin_addr;

    always_comb begin
        wr_req.wdata = bus_in;
        wr_req.lanes = (op == OP_WRITE) ? lanes : '0;
    end

    // Registered read return: one cycle after the read cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_out <= '0;
            bus_drv <= '0;
        end else if (op == OP_READ) begin
            bus_out <= mask_word(rd_word, lanes);
            bus_drv <= lanes;
        end else begin
            bus_out <= '0;
            bus_drv <= '0;
        end
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store
    import dpram_admux_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_a,
    input  wr_req_t           wr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  wr_req_t           wr_b,
    output word_t             rd_a,
    output word_t             rd_b
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        // Port a is written last so it wins a same-lane collision
        always_ff @(posedge clk) begin
            if (wr_b.lanes[g])
                bank[addr_b] <= wr_b.wdata[g*BYTE_W +: BYTE_W];
            if (wr_a.lanes[g])
                bank[addr_a] <= wr_a.wdata[g*BYTE_W +: BYTE_W];
        end

        assign rd_a[g*BYTE_W +: BYTE_W] = bank[addr_a];
        assign rd_b[g*BYTE_W +: BYTE_W] = bank[addr_b];
    end

endmodule

// File: rtl/dpram_admux.sv
module dpram_admux
    import dpram_admux_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              r_mux_mode,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic              l_out_en_n,
    input  logic              l_hi_en_n,
    input  logic              l_lo_en_n,
    input  logic              l_addr_stb,
    input  logic [15:0]       l_bus_in,
    output logic [15:0]       l_bus_out,
    output logic [1:0]        l_bus_drv,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic              r_out_en_n,
    input  logic              r_hi_en_n,
    input  logic              r_lo_en_n,
    input  logic              r_addr_stb,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [15:0]       r_bus_in,
    output logic [15:0]       r_bus_out,
    output logic [1:0]        r_bus_drv
);

    logic [ADDR_W-1:0] l_acc_addr, r_acc_addr;
    wr_req_t           l_wr, r_wr;
    word_t             l_rd, r_rd;

    dpram_port #(.ADDR_W(ADDR_W)) left_i (
        .clk      (clk),
        .rst      (rst),
        .mux_en   (1'b1),
        .stb      (l_addr_stb),
        .sel_n    (l_sel_n),
        .wr_n     (l_wr_n),
        .out_en_n (l_out_en_n),
        .hi_n     (l_hi_en_n),
        .lo_n     (l_lo_en_n),
        .bus_in   (l_bus_in),
        .pin_addr ({ADDR_W{1'b0}}),
        .rd_word  (l_rd),
        .acc_addr (l_acc_addr),
        .wr_req   (l_wr),
        .bus_out  (l_bus_out),
        .bus_drv  (l_bus_drv)
    );

    dpram_port #(.ADDR_W(ADDR_W)) right_i (
        .clk      (clk),
        .rst      (rst),
        .mux_en   (r_mux_mode),
        .stb      (r_addr_stb),
        .sel_n    (r_sel_n),
        .wr_n     (r_wr_n),
        .out_en_n (r_out_en_n),
        .hi_n     (r_hi_en_n),
        .lo_n     (r_lo_en_n),
        .bus_in   (r_bus_in),
        .pin_addr (r_addr),
        .rd_word  (r_rd),
        .acc_addr (r_acc_addr),
        .wr_req   (r_wr),
        .bus_out  (r_bus_out),
        .bus_drv  (r_bus_drv)
    );

    dpram_store #(.ADDR_W(ADDR_W)) store_i (
        .clk    (clk),
        .addr_a (l_acc_addr),
        .wr_a   (l_wr),
        .addr_b (r_acc_addr),
        .wr_b   (r_wr),
        .rd_a   (l_rd),
        .rd_b   (r_rd)
    );

endmodule

// File: rtl/dpram_admux_chk.sv
module dpram_admux_chk (
    input logic       clk,
    input logic       rst,
    input logic       r_mux_mode,
    input logic       l_sel_n,
    input logic       l_wr_n,
    input logic       l_out_en_n,
    input logic       l_hi_en_n,
    input logic       l_lo_en_n,
    input logic       l_addr_stb,
    input logic [1:0] l_bus_drv,
    input logic       r_sel_n,
    input logic       r_wr_n,
    input logic       r_out_en_n,
    input logic       r_hi_en_n,
    input logic       r_lo_en_n,
    input logic       r_addr_stb,
    input logic [1:0] r_bus_drv
);

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (l_bus_drv == 2'b00 && r_bus_drv == 2'b00));

    // R1
    strobe_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        l_addr_stb |=> (l_bus_drv == 2'b00));

    // R4
    l_deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        l_sel_n |=> (l_bus_drv == 2'b00));

    // R4
    r_deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        r_sel_n |=> (r_bus_drv == 2'b00));

    // R5
    out_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (l_wr_n && l_out_en_n) |=> (l_bus_drv == 2'b00));

    // R6
    lanes_off_chk: assert property (@(posedge clk) disable iff (rst)
        (r_hi_en_n && r_lo_en_n) |=> (r_bus_drv == 2'b00));

    // R7
    write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_sel_n && !l_wr_n) |=> (l_bus_drv == 2'b00));

    // R3
    l_read_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_addr_stb && !l_sel_n && l_wr_n && !l_out_en_n)
        |=> (l_bus_drv == {~$past(l_hi_en_n), ~$past(l_lo_en_n)}));

    // R2
    r_read_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!(r_mux_mode && r_addr_stb) && !r_sel_n && r_wr_n && !r_out_en_n)
        |=> (r_bus_drv == {~$past(r_hi_en_n), ~$past(r_lo_en_n)}));

endmodule

bind dpram_admux dpram_admux_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .r_mux_mode (r_mux_mode),
    .l_sel_n    (l_sel_n),
    .l_wr_n     (l_wr_n),
    .l_out_en_n (l_out_en_n),
    .l_hi_en_n  (l_hi_en_n),
    .l_lo_en_n  (l_lo_en_n),
    .l_addr_stb (l_addr_stb),
    .l_bus_drv  (l_bus_drv),
    .r_sel_n    (r_sel_n),
    .r_wr_n     (r_wr_n),
    .r_out_en_n (r_out_en_n),
    .r_hi_en_n  (r_hi_en_n),
    .r_lo_en_n  (r_lo_en_n),
    .r_addr_stb (r_addr_stb),
    .r_bus_drv  (r_bus_drv)
);

// File: tb/dpram_admux_tb.sv
`timescale 1ns/1ps
module dpram_admux_tb_top;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          r_mux_mode;
    logic          l_sel_n, l_wr_n, l_out_en_n, l_hi_en_n, l_lo_en_n, l_addr_stb;
    logic [15:0]   l_bus_in, l_bus_out;
    logic [1:0]    l_bus_drv;
    logic          r_sel_n, r_wr_n, r_out_en_n, r_hi_en_n, r_lo_en_n, r_addr_stb;
    logic [AW-1:0] r_addr;
    logic [15:0]   r_bus_in, r_bus_out;
    logic [1:0]    r_bus_drv;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] shadow [1 << AW];
    logic [17:0] got;

    always #2 clk = ~clk;

    dpram_admux #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .r_mux_mode(r_mux_mode),
        .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_out_en_n(l_out_en_n),
        .l_hi_en_n(l_hi_en_n), .l_lo_en_n(l_lo_en_n), .l_addr_stb(l_addr_stb),
        .l_bus_in(l_bus_in), .l_bus_out(l_bus_out), .l_bus_drv(l_bus_drv),
        .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_out_en_n(r_out_en_n),
        .r_hi_en_n(r_hi_en_n), .r_lo_en_n(r_lo_en_n), .r_addr_stb(r_addr_stb),
        .r_addr(r_addr), .r_bus_in(r_bus_in), .r_bus_out(r_bus_out),
        .r_bus_drv(r_bus_drv)
    );

    // {wport, rport, rmode, wlanes[1:0], rlanes[1:0], addr[11:0], data[15:0]}
    localparam logic [34:0] VECS [12] = '{
        {1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 12'h0A5, 16'h1234},
        {1'b1, 1'b0, 1'b0, 2'b10, 2'b11, 12'h0A5, 16'h5600},
        {1'b0, 1'b1, 1'b0, 2'b11, 2'b01, 12'hFFF, 16'hBEEF},
        {1'b1, 1'b0, 1'b1, 2'b11, 2'b10, 12'h001, 16'hCAFE},
        {1'b0, 1'b1, 1'b0, 2'b01, 2'b11, 12'h001, 16'h1177},
        {1'b1, 1'b1, 1'b0, 2'b11, 2'b11, 12'h800, 16'h0F0F},
        {1'b0, 1'b0, 1'b0, 2'b10, 2'b11, 12'h800, 16'hA5C3},
        {1'b1, 1'b1, 1'b1, 2'b11, 2'b01, 12'h123, 16'hFFFF},
        {1'b1, 1'b0, 1'b1, 2'b01, 2'b11, 12'h123, 16'h0000},
        {1'b0, 1'b1, 1'b1, 2'b11, 2'b10, 12'h7FE, 16'h8001},
        {1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 12'h7FE, 16'h1234},
        {1'b0, 1'b1, 1'b0, 2'b11, 2'b11, 12'h3C3, 16'h3C3C}
    };

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] lanes);
        return {lanes[1] ? nw[15:8] : old[15:8], lanes[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [17:0] expect_rd(input logic [15:0] w, input logic [1:0] lanes);
        return {lanes, lanes[1] ? w[15:8] : 8'h00, lanes[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_sel_n = 1'b1; l_wr_n = 1'b1; l_out_en_n = 1'b1;
        l_hi_en_n = 1'b1; l_lo_en_n = 1'b1; l_addr_stb = 1'b0; l_bus_in = '0;
        r_sel_n = 1'b1; r_wr_n = 1'b1; r_out_en_n = 1'b1;
        r_hi_en_n = 1'b1; r_lo_en_n = 1'b1; r_addr_stb = 1'b0; r_bus_in = '0;
        r_addr = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic latch(input bit p, input logic [AW-1:0] a);
        if (!p) begin l_addr_stb = 1'b1; l_bus_in = 16'(a); end
        else    begin r_addr_stb = 1'b1; r_bus_in = 16'(a); end
        tick();
        idle();
    endtask

    task automatic set_addr(input bit p, input logic [AW-1:0] a);
        if (p && !r_mux_mode) r_addr = a;
        else latch(p, a);
    endtask

    task automatic set_write(input bit p, input logic [15:0] d, input logic [1:0] lanes);
        if (!p) begin
            l_sel_n = 1'b0; l_wr_n = 1'b0; l_out_en_n = 1'b0;
            l_hi_en_n = ~lanes[1]; l_lo_en_n = ~lanes[0]; l_bus_in = d;
        end else begin
            r_sel_n = 1'b0; r_wr_n = 1'b0; r_out_en_n = 1'b0;
            r_hi_en_n = ~lanes[1]; r_lo_en_n = ~lanes[0]; r_bus_in = d;
        end
    endtask

    task automatic set_read(input bit p, input logic [1:0] lanes);
        if (!p) begin
            l_sel_n = 1'b0; l_wr_n = 1'b1; l_out_en_n = 1'b0;
            l_hi_en_n = ~lanes[1]; l_lo_en_n = ~lanes[0];
        end else begin
            r_sel_n = 1'b0; r_wr_n = 1'b1; r_out_en_n = 1'b0;
            r_hi_en_n = ~lanes[1]; r_lo_en_n = ~lanes[0];
        end
    endtask

    function automatic logic [17:0] port_out(input bit p);
        return p ? {r_bus_drv, r_bus_out} : {l_bus_drv, l_bus_out};
    endfunction

    task automatic do_write(input bit p, input logic [AW-1:0] a, input logic [15:0] d,
                            input logic [1:0] lanes);
        set_addr(p, a);
        set_write(p, d, lanes);
        tick();
        idle();
        shadow[a] = merge(shadow[a], d, lanes);
    endtask

    task automatic do_read(input bit p, input logic [AW-1:0] a, input logic [1:0] lanes,
                           output logic [17:0] res);
        set_addr(p, a);
        set_read(p, lanes);
        tick();
        res = port_out(p);
        idle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        r_mux_mode = 1'b0;
        idle();
        @(negedge clk);
        repeat (3) tick();
        // R11: reset state of both ports
        check("R11 left reset", {l_bus_drv, l_bus_out}, 18'h0);
        check("R11 right reset", {r_bus_drv, r_bus_out}, 18'h0);
        rst = 1'b0;
        tick();

        // R11: no strobe yet, left writes word 0, right (mux) reads word 0
        set_write(0, 16'h4321, 2'b11);
        tick();
        idle();
        shadow[0] = 16'h4321;
        r_mux_mode = 1'b1;
        set_read(1, 2'b11);
        tick();
        check("R11 right default address", port_out(1), expect_rd(16'h4321, 2'b11));
        idle();
        set_read(0, 2'b11);
        tick();
        check("R11 left default address", port_out(0), expect_rd(16'h4321, 2'b11));
        idle();

        // Table of writes and reads: R3/R7/R6 with R2 addressing modes
        for (int i = 0; i < 12; i++) begin
            logic [34:0] v;
            v = VECS[i];
            r_mux_mode = v[32];
            tick();
            do_write(v[34], v[27:16], v[15:0], v[31:30]);
            do_read(v[33], v[27:16], v[29:28], got);
            check((v[31:30] == 2'b00) ? "R6 vector" : "R3/R7 vector",
                  got, expect_rd(shadow[v[27:16]], v[29:28]));
        end

        // R1: strobe cycle with write controls neither drives nor writes
        r_mux_mode = 1'b1;
        l_addr_stb = 1'b1; l_bus_in = 16'h00A5;
        l_sel_n = 1'b0; l_wr_n = 1'b0; l_hi_en_n = 1'b0; l_lo_en_n = 1'b0;
        tick();
        check("R1 strobe no drive", port_out(0), 18'h0);
        idle();
        set_read(0, 2'b11);
        tick();
        check("R1 strobe no write", port_out(0), expect_rd(shadow[12'h0A5], 2'b11));
        idle();

        // R2: strobe ignored in pin-address mode
        latch(1, 12'h001);
        r_mux_mode = 1'b0;
        r_addr = 12'h0A5; r_addr_stb = 1'b1; r_bus_in = 16'h0FFF;
        set_read(1, 2'b11);
        tick();
        check("R2 pin mode read with strobe", port_out(1), expect_rd(shadow[12'h0A5], 2'b11));
        idle();
        r_mux_mode = 1'b1;
        set_read(1, 2'b11);
        tick();
        check("R2 stored address kept", port_out(1), expect_rd(shadow[12'h001], 2'b11));
        idle();

        // R4: deselected write has no effect
        l_sel_n = 1'b1; l_wr_n = 1'b0; l_out_en_n = 1'b0;
        l_hi_en_n = 1'b0; l_lo_en_n = 1'b0; l_bus_in = 16'hDEAD;
        tick();
        check("R4 deselect no drive", port_out(0), 18'h0);
        idle();
        set_read(0, 2'b11);
        tick();
        check("R4 deselect no write", port_out(0), expect_rd(shadow[12'h0A5], 2'b11));
        idle();

        // R5: output disabled read
        set_read(0, 2'b11);
        l_out_en_n = 1'b1;
        tick();
        check("R5 output disable", port_out(0), 18'h0);
        idle();

        // R8: both ports read the same word together
        r_mux_mode = 1'b0;
        r_addr = 12'h0A5;
        set_read(0, 2'b11);
        set_read(1, 2'b11);
        tick();
        check("R8 left shared read", port_out(0), expect_rd(shadow[12'h0A5], 2'b11));
        check("R8 right shared read", port_out(1), expect_rd(shadow[12'h0A5], 2'b11));
        idle();

        // R9: write collision, left wins per lane
        r_mux_mode = 1'b1;
        latch(0, 12'h123);
        latch(1, 12'h123);
        set_write(0, 16'h1111, 2'b11);
        set_write(1, 16'h2222, 2'b11);
        tick();
        idle();
        set_read(0, 2'b11);
        tick();
        check("R9 full collision", port_out(0), expect_rd(16'h1111, 2'b11));
        idle();
        set_write(0, 16'h3333, 2'b01);
        set_write(1, 16'h4444, 2'b11);
        tick();
        idle();
        set_read(1, 2'b11);
        tick();
        check("R9 per-lane collision", port_out(1), expect_rd(16'h4433, 2'b11));
        idle();

        // R10: read during a write by the other port returns old data
        latch(0, 12'h7FE);
        r_mux_mode = 1'b0;
        r_addr = 12'h7FE;
        set_write(0, 16'h5555, 2'b11);
        set_read(1, 2'b11);
        tick();
        check("R10 old data", port_out(1), expect_rd(shadow[12'h7FE], 2'b11));
        idle();
        shadow[12'h7FE] = 16'h5555;
        r_addr = 12'h7FE;
        set_read(1, 2'b11);
        tick();
        check("R10 new data after", port_out(1), expect_rd(16'h5555, 2'b11));
        idle();

        tick();
        finish_run();
    end

endmodule